// File: doc/BRIEF.md
# Chainable TDM Audio Serial Port

This block is the serial audio port of one converter device. It carries eight sample slots per device, in the order L1, L2, L3, L4, R1, R2, R3, R4. Each slot is 32 bit-clocks long. Each device holds a 256-bit frame register. At every frame boundary the register is filled with the device's ADC samples, and the completed frame it has just received is handed to the DAC outputs. Between boundaries the register shifts one bit per bit-clock period. The old contents leave on `sdout` while new bits enter on `sdin`.

Two devices form a chain. The host's transmit line feeds the second device. The second device's output feeds the first device. The first device's output feeds the host. Over a 512-bit frame the host therefore receives both devices' ADC words, and its own DAC words come to rest across the two registers. No arbitration logic is needed. A strap input selects the role. The master divides the shared clock to make the bit clock and the frame sync. A slave takes both from the master. All logic runs on the shared master clock, and bit-clock edges are treated as enables.

Top module: `tdm_chain_port`

## Requirements
- R1: In master mode `bclk_out` toggles every CLK_DIV clock cycles, giving a period of 2*CLK_DIV cycles with equal high and low halves.
- R2: In master mode `fsync_out` rises and falls only together with a falling edge of `bclk_out`. It stays high for exactly one bit period, once every DEVICES*256 bit periods. That period is the one just before bit 0 of the frame.
- R3: In slave mode `bclk_out` and `fsync_out` stay low, and the port is timed by `bclk_in` and `fsync_in`.
- R4: The ADC samples are loaded at the frame boundary. Slot s (0 = L1 … 7 = R4) is taken from `adc_words[s*24 +: 24]`. It is sent in frame bit periods s*32 to s*32+31, MSB first, with the 8 bits after the LSB sent as 0.
- R5: A change of `adc_words` after a frame boundary has no effect on the frame being sent.
- R6: `sdout` changes only after a bit-clock falling edge, and `sdin` is sampled on the rising edge. A device sends its own 256 ADC bits first and then repeats its `sdin` delayed by 256 bit periods. The host therefore receives device 1's frame in bits 0–255 and device 2's frame in bits 256–511.
- R7: At each boundary after the first, `dac_words[s*24 +: 24]` takes the first 24 bits (MSB first) of slot s from the 256 bits held at the end of the frame. The 8 tail bits of each slot are ignored. `dac_words` does not change between boundaries.
- R8: Until the first frame sync after reset, `sdout` is 0. `dac_words` stays 0 through the first boundary and first changes at the second boundary.
- R9: During and right after reset, `bclk_out`, `fsync_out`, `sdout` and `dac_words` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared master clock |
| rst_n | input | 1 | Active-low reset, shared by the chain |
| is_master | input | 1 | Static strap: 1 master, 0 slave |
| bclk_in | input | 1 | Bit clock from the master (slave mode) |
| fsync_in | input | 1 | Frame sync from the master (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode, else 0) |
| fsync_out | output | 1 | Generated frame sync (master mode, else 0) |
| sdin | input | 1 | Chain serial input |
| sdout | output | 1 | Chain serial output |
| adc_words | input | 192 | Eight 24-bit ADC samples, slot 0 in the low bits |
| dac_words | output | 192 | Eight 24-bit DAC samples, slot 0 in the low bits |

## Verification
The assertions assume the strap does not change while out of reset. They also assume a slave's `bclk_in` and `fsync_in` come from a master running on the same clock, so that half periods last at least two cycles and the sync moves only with a falling edge. The bench meets both conditions by wiring a fixed-strap slave straight to the master's generated outputs. It acts as the host only on edges it sees on `bclk_out`, and drives and samples at mid-cycle. Its ADC words change only well inside a frame, so the load at each boundary sees settled inputs.

// File: rtl/tdm_chain_port.sv
module tdm_chain_port #(
  parameter int SLOTS    = 8,
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24,
  parameter int DEVICES  = 2,
  parameter int CLK_DIV  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      is_master,
  input  logic                      bclk_in,
  input  logic                      fsync_in,
  output logic                      bclk_out,
  output logic                      fsync_out,
  input  logic                      sdin,
  output logic                      sdout,
  input  logic [SLOTS*SAMPLE_W-1:0] adc_words,
  output logic [SLOTS*SAMPLE_W-1:0] dac_words
);
  localparam int REG_W      = SLOTS * SLOT_W;
  localparam int FRAME_BITS = DEVICES * REG_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int DIV_W      = $clog2(CLK_DIV);
  localparam int PAD_W      = SLOT_W - SAMPLE_W;

  logic [DIV_W-1:0]          div_cnt;
  logic [CNT_W-1:0]          gen_bit;
  logic                      bclk_q, fs_q;
  logic                      bclk_d, fs_seen, in_bit, synced;
  logic [REG_W-1:0]          sreg, adc_frame;
  logic [SLOTS*SAMPLE_W-1:0] dac_q, dac_next;

  wire div_wrap = div_cnt == DIV_W'(CLK_DIV - 1);
  wire [CNT_W-1:0] gen_next = (gen_bit == CNT_W'(FRAME_BITS - 1)) ? '0 : gen_bit + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
      fs_q    <= 1'b0;
      gen_bit <= '0;
    end else if (is_master) begin
      div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
      if (div_wrap) begin
        bclk_q <= ~bclk_q;
        if (bclk_q) begin
          gen_bit <= gen_next;
          fs_q    <= gen_next == CNT_W'(FRAME_BITS - 1);
        end
      end
    end
  end

  assign bclk_out  = bclk_q;
  assign fsync_out = fs_q;

  wire bclk_sel = is_master ? bclk_q : bclk_in;
  wire fs_sel   = is_master ? fs_q   : fsync_in;
  wire rise_ev  = bclk_sel & ~bclk_d;
  wire fall_ev  = ~bclk_sel & bclk_d;
  wire [REG_W-1:0] shifted = {sreg[REG_W-2:0], in_bit};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (PAD_W > 0) begin : g_pad
      assign adc_frame[REG_W-1-s*SLOT_W -: SLOT_W] =
        {adc_words[s*SAMPLE_W +: SAMPLE_W], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign adc_frame[REG_W-1-s*SLOT_W -: SLOT_W] = adc_words[s*SAMPLE_W +: SAMPLE_W];
    end
    assign dac_next[s*SAMPLE_W +: SAMPLE_W] = shifted[REG_W-1-s*SLOT_W -: SAMPLE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d  <= 1'b0;
      fs_seen <= 1'b0;
      in_bit  <= 1'b0;
      synced  <= 1'b0;
      sreg    <= '0;
      dac_q   <= '0;
    end else begin
      bclk_d <= bclk_sel;
      if (rise_ev) begin
        in_bit  <= sdin;
        fs_seen <= fs_sel;
      end
      if (fall_ev) begin
        if (fs_seen) begin
          sreg   <= adc_frame;
          synced <= 1'b1;
          if (synced) dac_q <= dac_next;
        end else begin
          sreg <= shifted;
        end
      end
    end
  end

  assign sdout     = synced & sreg[REG_W-1];
  assign dac_words = dac_q;

  logic             chk_b;
  logic [DIV_W:0]   chk_hc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_b  <= 1'b0;
      chk_hc <= '0;
    end else begin
      chk_b  <= bclk_out;
      chk_hc <= (bclk_out != chk_b) ? (DIV_W+1)'(1) : chk_hc + 1'b1;
    end
  end

  assert_bclk_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && (bclk_out != chk_b) |-> chk_hc == (DIV_W+1)'(CLK_DIV));

  assert_fsync_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && $rose(fsync_out) |-> $fell(bclk_out));

  assert_fsync_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && $fell(fsync_out) |-> $fell(bclk_out));

  assert_slave_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !bclk_out && !fsync_out);

  assert_sdout_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(sdout));

  assert_dac_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_ev && fs_seen) |=> $stable(dac_words));

  assert_dac_unsynced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> dac_words == '0);
endmodule

// File: tb/tb_tdm_chain_port.sv
module tb_tdm_chain_port;
  localparam int NS = 8, SW = 24, DIV = 2, FB = 512;
  localparam int NV = 5;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 32'h1234_5678}, {2'd1, 32'h0}, {2'd0, 32'hDEAD_BEEF},
    {2'd2, 32'h0},         {2'd0, 32'h0F0F_A5A5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_tx = 1'b0;
  logic [NS*SW-1:0] adc1 = '0, adc2 = '0;
  logic bclk1, fs1, sd1, bclk2, fs2, sd2;
  logic [NS*SW-1:0] dac1, dac2;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  tdm_chain_port dut (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1), .bclk_in(1'b0), .fsync_in(1'b0),
    .bclk_out(bclk1), .fsync_out(fs1), .sdin(sd2), .sdout(sd1),
    .adc_words(adc1), .dac_words(dac1));

  tdm_chain_port dut2 (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0), .bclk_in(bclk1), .fsync_in(fs1),
    .bclk_out(bclk2), .fsync_out(fs2), .sdin(host_tx), .sdout(sd2),
    .adc_words(adc2), .dac_words(dac2));

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input logic [31:0] a);
    logic [31:0] w = a * 32'h9E37_79B1;
    return w ^ (w >> 15) ^ (w << 7);
  endfunction

  function automatic logic [NS*SW-1:0] mk_adc(input logic [33:0] v, input int dev);
    logic [NS*SW-1:0] r = '0;
    for (int s = 0; s < NS; s++) begin
      logic [31:0] w = mix(v[31:0] + 32'(s + 16 * dev));
      r[s*SW +: SW] = (v[33:32] == 2'd1) ? '1 : (v[33:32] == 2'd2) ? '0 : w[SW-1:0];
    end
    return r;
  endfunction

  function automatic logic [FB-1:0] mk_host(input logic [33:0] v);
    logic [FB-1:0] r = '0;
    for (int k = 0; k < FB / 32; k++)
      r[k*32 +: 32] = (v[33:32] == 2'd1) ? '1 : (v[33:32] == 2'd2) ? '0 : mix(v[31:0] ^ 32'(k * 77 + 5));
    return r;
  endfunction

  function automatic logic [255:0] adc_stream(input logic [NS*SW-1:0] a);
    logic [255:0] r = '0;
    for (int s = 0; s < NS; s++)
      for (int j = 0; j < SW; j++) r[s*32 + j] = a[s*SW + SW - 1 - j];
    return r;
  endfunction

  function automatic logic [NS*SW-1:0] exp_dac(input logic [FB-1:0] h, input int dev);
    logic [NS*SW-1:0] r = '0;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < SW; k++) r[s*SW + k] = h[dev*256 + s*32 + SW - 1 - k];
    return r;
  endfunction

  logic [FB-1:0] host_cur = '1, host_next = '1, rx_cur = '0, rx_last = '0;
  logic prevb = 1'b0, armed = 1'b0;
  int idx = 0, frm = 0, rises_since = 0, fs_gap = 0, fs_run = 0, fs_run_max = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prevb = 1'b0; armed = 1'b0; idx = 0; frm = 0; rises_since = 0; fs_run = 0;
    end else begin
      if (prevb && !bclk1) begin
        if (armed) begin
          idx = 0; frm++; rx_last = rx_cur; host_cur = host_next;
        end else idx++;
        host_tx = (idx < FB) ? host_cur[idx] : 1'b0;
      end
      if (!prevb && bclk1) begin
        if (idx < FB) rx_cur[idx] = sd1;
        armed = fs1;
        rises_since++;
        if (fs1) begin
          if (fs_run == 0 && frm > 0) fs_gap = rises_since;
          rises_since = 0;
          fs_run++;
          if (fs_run > fs_run_max) fs_run_max = fs_run;
        end else fs_run = 0;
      end
      prevb = bclk1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog frame=%0d", frm);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hi_cnt, per_cnt;
    repeat (3) @(negedge clk);
    chk({bclk1, fs1, sd1, sd2} == 4'b0 && dac1 == '0 && dac2 == '0, "R9 reset state",
        {bclk1, fs1, sd1, sd2}, 0);
    adc1 = mk_adc(VEC[0], 0); adc2 = mk_adc(VEC[0], 1); host_next = mk_host(VEC[0]);
    @(negedge clk) rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk(sd1 == 1'b0 && sd2 == 1'b0, "R8 sdout quiet before sync", {sd1, sd2}, 0);
    chk(bclk2 == 1'b0 && fs2 == 1'b0, "R3 slave outputs low", {bclk2, fs2}, 0);

    @(posedge bclk1); @(negedge clk);
    hi_cnt = 0; per_cnt = 0;
    while (bclk1) begin hi_cnt++; per_cnt++; @(negedge clk); end
    while (!bclk1) begin per_cnt++; @(negedge clk); end
    chk(hi_cnt == DIV, "R1 bclk high half", hi_cnt, DIV);
    chk(per_cnt == 2 * DIV, "R1 bclk period", per_cnt, 2 * DIV);

    for (int i = 0; i < NV; i++) begin
      logic [NS*SW-1:0] keep1, keep2;
      wait (frm == i + 1);
      repeat (8) @(negedge clk);
      if (i == 0) chk(dac1 == '0 && dac2 == '0, "R8 dac holds at first boundary", dac1, 0);
      keep1 = dac1; keep2 = dac2;
      if (i + 1 < NV) begin
        adc1 = mk_adc(VEC[i+1], 0); adc2 = mk_adc(VEC[i+1], 1); host_next = mk_host(VEC[i+1]);
      end
      repeat (1000) @(negedge clk);
      chk(dac1 == keep1 && dac2 == keep2, "R7 dac stable mid-frame", dac1, keep1);
      chk(bclk2 == 1'b0 && fs2 == 1'b0, "R3 slave outputs low", {bclk2, fs2}, 0);
      wait (frm == i + 2);
      repeat (8) @(negedge clk);
      chk(rx_last[255:0] == adc_stream(mk_adc(VEC[i], 0)), "R4 R5 device 1 slots",
          rx_last[255:0], adc_stream(mk_adc(VEC[i], 0)));
      chk(rx_last[511:256] == adc_stream(mk_adc(VEC[i], 1)), "R6 chained device 2 slots",
          rx_last[511:256], adc_stream(mk_adc(VEC[i], 1)));
      chk(dac1 == exp_dac(mk_host(VEC[i]), 0), "R7 device 1 dac", dac1, exp_dac(mk_host(VEC[i]), 0));
      chk(dac2 == exp_dac(mk_host(VEC[i]), 1), "R7 device 2 dac", dac2, exp_dac(mk_host(VEC[i]), 1));
    end

    chk(fs_gap == FB, "R2 fsync spacing", fs_gap, FB);
    chk(fs_run_max == 1, "R2 fsync width", fs_run_max, 1);

    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({bclk1, fs1, sd1, sd2} == 4'b0 && dac1 == '0 && dac2 == '0, "R9 state after re-reset",
        {bclk1, fs1, sd1, sd2, dac1[7:0]}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule